// File: doc/BRIEF.md
# ASID-Tagged Translation Cache with Superpage Support

This block is a small fully associative cache of completed address translations. Each entry holds an address-space tag (ASID), a global flag, a virtual page number kept under a per-entry match mask, a physical base, the leaf attribute byte and the physical address of the leaf entry. Because the mask is derived from the level at which a walk ended, one structure holds 4 KiB, 2 MiB and 1 GiB pages side by side.

A lookup is purely combinational from stored state. It takes the current ASID and a 39-bit virtual address and returns a hit flag, the entry index, the assembled 56-bit physical address, the attribute byte and the leaf's physical address. The walker writes new translations through the fill port. Once it has set the accessed or dirty bits, it rewrites an entry's attribute byte through the update port. Fence logic removes entries through the flush port, which selects by ASID, by address, by both or by neither. Walking and permission policy live outside this block.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid: every lookup misses, and a missing lookup drives `lk_pa`, `lk_attr`, `lk_leaf_pa` and `lk_idx` to zero.
- R2: A fill at level L (0, 1 or 2) uses a page shift of 12 + 9·L. The stored virtual address keeps only the bits at and above the shift, and the stored physical base has its low shift bits cleared.
- R3: An entry hits when it is valid, its stored virtual address equals the lookup address ANDed with the entry's match mask, and it is either global or its ASID equals `lk_asid`.
- R4: On a hit, `lk_pa` is the stored physical base ORed with the lookup address bits below the page shift. `lk_attr` and `lk_leaf_pa` return the entry's attribute byte and leaf address.
- R5: When several entries hit, `lk_idx` and the returned data come from the lowest-numbered one.
- R6: A fill writes the lowest-numbered invalid entry if one exists. Otherwise it writes the entry chosen by a round-robin pointer, which starts at 0 and advances by one, wrapping, only on fills that replace a valid entry.
- R7: A fill with level value 3 is dropped. No entry changes and the round-robin pointer does not move.
- R8: An update with index k writes `upd_attr` into entry k's attribute byte and leaves its address, tag and mask fields unchanged.
- R9: A flush with neither `fl_by_asid` nor `fl_by_va` set invalidates every entry.
- R10: A flush with only `fl_by_va` set invalidates every entry, global ones included, whose stored address equals `fl_va` under that entry's mask.
- R11: A flush with only `fl_by_asid` set invalidates non-global entries whose ASID equals `fl_asid`. Global entries survive.
- R12: A flush with both selectors set invalidates non-global entries that match both `fl_asid` and `fl_va`. Global entries survive.
- R13: Fill, update and flush take effect at the next rising clock edge. A fill or update presented in the same cycle as a flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_asid | input | 16 | Current ASID for lookup |
| lk_va | input | 39 | Lookup virtual address |
| lk_hit | output | 1 | Some entry matches |
| lk_idx | output | 3 | Index of the matching entry (lowest) |
| lk_pa | output | 56 | Translated physical address |
| lk_attr | output | 8 | Attribute byte of the matching entry |
| lk_leaf_pa | output | 56 | Physical address of the matching leaf |
| fill_en | input | 1 | Write a new translation |
| fill_asid | input | 16 | ASID of the new translation |
| fill_glb | input | 1 | New translation is global |
| fill_va | input | 39 | Virtual address of the new translation |
| fill_pa | input | 56 | Physical address from the walk |
| fill_lvl | input | 2 | Level at which the walk ended (0..2) |
| fill_attr | input | 8 | Leaf attribute byte |
| fill_leaf_pa | input | 56 | Physical address of the leaf |
| upd_en | input | 1 | Rewrite an entry's attribute byte |
| upd_idx | input | 3 | Entry to rewrite |
| upd_attr | input | 8 | New attribute byte |
| fl_en | input | 1 | Flush request |
| fl_by_asid | input | 1 | Flush selects by ASID |
| fl_by_va | input | 1 | Flush selects by address |
| fl_asid | input | 16 | ASID for a selective flush |
| fl_va | input | 39 | Address for a selective flush |

## Verification
On every cycle the assertions check that a reported hit names a valid, actually matching entry with no lower matching entry. They check that every valid entry keeps its stored address clear below its mask, that a full flush empties the array, that global entries outlive any ASID-qualified flush, and that fills and updates land in the entry they targeted. The exact translated addresses for each page size, the ASID and global matching rules, the round-robin order once the array is full, the dropped level-3 fill and the dropping of fills that meet a flush can only be shown by the bench's scenarios.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;

    parameter int VA_W     = 39;
    parameter int PA_W     = 56;
    parameter int ASID_W   = 16;
    parameter int ATTR_W   = 8;
    parameter int LVL_W    = 2;
    parameter int PG_BITS  = 12;
    parameter int LVL_BITS = 9;
    parameter int LVL_MAX  = 2;

    typedef struct packed {
        logic              vld;
        logic              glb;
        logic [ASID_W-1:0] asid;
        logic [VA_W-1:0]   va;
        logic [VA_W-1:0]   mmask;
        logic [PA_W-1:0]   pa;
        logic [ATTR_W-1:0] attr;
        logic [PA_W-1:0]   leaf_pa;
    } ent_t;

    // Bits below the page shift for a given level.
    function automatic logic [VA_W-1:0] off_mask(input logic [LVL_W-1:0] lvl);
        logic [VA_W-1:0] m;
        int sh;
        sh = PG_BITS + int'(lvl) * LVL_BITS;
        for (int i = 0; i < VA_W; i++) begin
            m[i] = (i < sh);
        end
        return m;
    endfunction

endpackage

// File: rtl/xlat_pick.sv
module xlat_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/xlat_way.sv
module xlat_way
    import xlat_cache_pkg::*;
(
    input  ent_t              ent_i,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic              fl_by_asid,
    input  logic              fl_by_va,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic [VA_W-1:0]   fl_va,
    output logic              hit_o,
    output logic              kill_o
);
    logic lk_va_ok, lk_tag_ok, fl_va_ok, fl_tag_ok;

    always_comb begin
        lk_va_ok  = (ent_i.va == (ent_i.mmask & lk_va));
        lk_tag_ok = ent_i.glb | (ent_i.asid == lk_asid);
        hit_o     = ent_i.vld & lk_va_ok & lk_tag_ok;

        fl_va_ok  = (ent_i.va == (ent_i.mmask & fl_va));
        fl_tag_ok = (ent_i.asid == fl_asid);
        unique case ({fl_by_asid, fl_by_va})
            2'b00:   kill_o = ent_i.vld;
            2'b01:   kill_o = ent_i.vld & fl_va_ok;
            2'b10:   kill_o = ent_i.vld & ~ent_i.glb & fl_tag_ok;
            default: kill_o = ent_i.vld & ~ent_i.glb & fl_tag_ok & fl_va_ok;
        endcase
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_cache_pkg::*;
#(
    parameter int NUM_ENT = 8,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_va,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [PA_W-1:0]   lk_pa,
    output logic [ATTR_W-1:0] lk_attr,
    output logic [PA_W-1:0]   lk_leaf_pa,
    input  logic              fill_en,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_glb,
    input  logic [VA_W-1:0]   fill_va,
    input  logic [PA_W-1:0]   fill_pa,
    input  logic [LVL_W-1:0]  fill_lvl,
    input  logic [ATTR_W-1:0] fill_attr,
    input  logic [PA_W-1:0]   fill_leaf_pa,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [ATTR_W-1:0] upd_attr,
    input  logic              fl_en,
    input  logic              fl_by_asid,
    input  logic              fl_by_va,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic [VA_W-1:0]   fl_va
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENT - 1);

    typedef struct packed {
        ent_t [NUM_ENT-1:0] ent;
        logic [IDX_W-1:0]   rr;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_ENT-1:0] hit_vec, kill_vec, vld_vec;
    logic               free_any;
    logic [IDX_W-1:0]   free_idx, hit_idx, victim;
    logic               fill_ok;
    logic [VA_W-1:0]    new_off;
    ent_t               new_ent, sel;

    // Per-entry compare for lookup and flush
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_way
        xlat_way u_way (
            .ent_i      (st_q.ent[g]),
            .lk_asid    (lk_asid),
            .lk_va      (lk_va),
            .fl_by_asid (fl_by_asid),
            .fl_by_va   (fl_by_va),
            .fl_asid    (fl_asid),
            .fl_va      (fl_va),
            .hit_o      (hit_vec[g]),
            .kill_o     (kill_vec[g])
        );
        assign vld_vec[g] = st_q.ent[g].vld;

        // R2
        va_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.ent[g].vld |-> ((st_q.ent[g].va & ~st_q.ent[g].mmask) == '0));

        // R11 R12
        glb_survive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fl_en && fl_by_asid && st_q.ent[g].vld && st_q.ent[g].glb) |=> st_q.ent[g].vld);
    end

    xlat_pick #(.N(NUM_ENT), .IW(IDX_W)) u_hit_pick (
        .req (hit_vec), .any (lk_hit), .idx (hit_idx)
    );

    xlat_pick #(.N(NUM_ENT), .IW(IDX_W)) u_free_pick (
        .req (~vld_vec), .any (free_any), .idx (free_idx)
    );

    // Lookup outputs
    always_comb begin
        sel = st_q.ent[hit_idx];
        if (lk_hit) begin
            lk_idx     = hit_idx;
            lk_pa      = sel.pa | PA_W'(lk_va & ~sel.mmask);
            lk_attr    = sel.attr;
            lk_leaf_pa = sel.leaf_pa;
        end else begin
            lk_idx     = '0;
            lk_pa      = '0;
            lk_attr    = '0;
            lk_leaf_pa = '0;
        end
    end

    // Next-state computation
    always_comb begin
        fill_ok = fill_en && (fill_lvl <= LVL_W'(LVL_MAX));
        victim  = free_any ? free_idx : st_q.rr;
        new_off = off_mask(fill_lvl);

        new_ent.vld     = 1'b1;
        new_ent.glb     = fill_glb;
        new_ent.asid    = fill_asid;
        new_ent.va      = fill_va & ~new_off;
        new_ent.mmask   = ~new_off;
        new_ent.pa      = fill_pa & ~PA_W'(new_off);
        new_ent.attr    = fill_attr;
        new_ent.leaf_pa = fill_leaf_pa;

        st_d = st_q;
        if (fl_en) begin
            for (int i = 0; i < NUM_ENT; i++) begin
                if (kill_vec[i]) st_d.ent[i].vld = 1'b0;
            end
        end else begin
            if (upd_en) st_d.ent[upd_idx].attr = upd_attr;
            if (fill_ok) begin
                st_d.ent[victim] = new_ent;
                if (!free_any) st_d.rr = (st_q.rr == LAST_IDX) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    lowest_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (hit_vec[lk_idx] && st_q.ent[lk_idx].vld
                    && ((hit_vec & ((NUM_ENT'(1) << lk_idx) - NUM_ENT'(1))) == '0)));

    // R9
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && !fl_by_asid && !fl_by_va) |=> (vld_vec == '0));

    // R6
    fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_ok && !fl_en) |=> (st_q.ent[$past(victim)].vld
                                  && st_q.ent[$past(victim)].attr == $past(fill_attr)));

    // R8
    upd_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !fl_en && !(fill_ok && victim == upd_idx))
        |=> (st_q.ent[$past(upd_idx)].attr == $past(upd_attr)));

endmodule

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;
    import xlat_cache_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       lk_asid = '0;
    logic [38:0]       lk_va = '0;
    logic              lk_hit;
    logic [2:0]        lk_idx;
    logic [55:0]       lk_pa;
    logic [7:0]        lk_attr;
    logic [55:0]       lk_leaf_pa;
    logic              fill_en = 1'b0;
    logic [15:0]       fill_asid = '0;
    logic              fill_glb = 1'b0;
    logic [38:0]       fill_va = '0;
    logic [55:0]       fill_pa = '0;
    logic [1:0]        fill_lvl = '0;
    logic [7:0]        fill_attr = '0;
    logic [55:0]       fill_leaf_pa = '0;
    logic              upd_en = 1'b0;
    logic [2:0]        upd_idx = '0;
    logic [7:0]        upd_attr = '0;
    logic              fl_en = 1'b0;
    logic              fl_by_asid = 1'b0;
    logic              fl_by_va = 1'b0;
    logic [15:0]       fl_asid = '0;
    logic [38:0]       fl_va = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    xlat_cache dut (
        .clk(clk), .rst_n(rst_n),
        .lk_asid(lk_asid), .lk_va(lk_va), .lk_hit(lk_hit), .lk_idx(lk_idx),
        .lk_pa(lk_pa), .lk_attr(lk_attr), .lk_leaf_pa(lk_leaf_pa),
        .fill_en(fill_en), .fill_asid(fill_asid), .fill_glb(fill_glb),
        .fill_va(fill_va), .fill_pa(fill_pa), .fill_lvl(fill_lvl),
        .fill_attr(fill_attr), .fill_leaf_pa(fill_leaf_pa),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_attr(upd_attr),
        .fl_en(fl_en), .fl_by_asid(fl_by_asid), .fl_by_va(fl_by_va),
        .fl_asid(fl_asid), .fl_va(fl_va)
    );

    // Vector: asid[122:107] va[106:68] hit[67] idx[66:64] pa[63:8] attr[7:0]
    localparam int NV = 8;
    localparam logic [122:0] VEC [NV] = '{
        {16'h0001, 39'h0012345ABC, 1'b1, 3'd0, 56'h00_0000_ABCD_EABC, 8'h0F}, // R2 R4 4 KiB
        {16'h0002, 39'h0012345ABC, 1'b0, 3'd0, 56'h0,                 8'h00}, // R3 ASID mismatch
        {16'h0007, 39'h00403ABCDE, 1'b1, 3'd1, 56'h00_0000_807A_BCDE, 8'h1F}, // R3 global, 2 MiB
        {16'h0007, 39'h0040400000, 1'b0, 3'd0, 56'h0,                 8'h00}, // R2 beyond 2 MiB
        {16'h0001, 39'h00BFFFFFFF, 1'b1, 3'd2, 56'h00_0001_7FFF_FFFF, 8'h2F}, // R4 1 GiB
        {16'h0003, 39'h00BFFFFFFF, 1'b0, 3'd0, 56'h0,                 8'h00}, // R3 non-global
        {16'h0001, 39'h0012346000, 1'b0, 3'd0, 56'h0,                 8'h00}, // R3 next page
        {16'h0001, 39'h0080001234, 1'b1, 3'd2, 56'h00_0001_4000_1234, 8'h2F}  // R5 overlap
    };

    task automatic check_lk(input string req, input logic [15:0] asid, input logic [38:0] va,
                            input logic ehit, input logic [2:0] eidx,
                            input logic [55:0] epa, input logic [7:0] eattr);
        @(negedge clk);
        lk_asid = asid;
        lk_va   = va;
        #2;
        n_chk++;
        if (lk_hit !== ehit || (ehit && (lk_idx !== eidx || lk_pa !== epa || lk_attr !== eattr))
            || (!ehit && (lk_pa !== '0 || lk_attr !== '0 || lk_idx !== '0))) begin
            n_fail++;
            $display("FAIL %s va=%h: got hit=%b idx=%0d pa=%h attr=%h, want hit=%b idx=%0d pa=%h attr=%h",
                     req, va, lk_hit, lk_idx, lk_pa, lk_attr, ehit, eidx, epa, eattr);
        end
    endtask

    task automatic do_fill(input logic [15:0] asid, input logic glb, input logic [38:0] va,
                           input logic [55:0] pa, input logic [1:0] lvl, input logic [7:0] attr);
        @(negedge clk);
        fill_en = 1'b1; fill_asid = asid; fill_glb = glb; fill_va = va;
        fill_pa = pa; fill_lvl = lvl; fill_attr = attr; fill_leaf_pa = pa ^ 56'h1000;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_flush(input logic by_asid, input logic by_va,
                            input logic [15:0] asid, input logic [38:0] va);
        @(negedge clk);
        fl_en = 1'b1; fl_by_asid = by_asid; fl_by_va = by_va; fl_asid = asid; fl_va = va;
        @(negedge clk);
        fl_en = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_lk("R1", 16'h0001, 39'h0012345ABC, 1'b0, 3'd0, 56'h0, 8'h00);
        check_lk("R1", 16'h0000, 39'h0, 1'b0, 3'd0, 56'h0, 8'h00);

        // Fills land in lowest invalid entries (R6), masked per level (R2)
        do_fill(16'h0001, 1'b0, 39'h0012345000, 56'hABCDE000, 2'd0, 8'h0F);
        do_fill(16'h0002, 1'b1, 39'h00403ABCDE, 56'h80612345, 2'd1, 8'h1F);
        do_fill(16'h0001, 1'b0, 39'h0081234567, 56'h140000000, 2'd2, 8'h2F);
        do_fill(16'h0001, 1'b0, 39'h0080001000, 56'h5000, 2'd0, 8'h3F);

        for (int v = 0; v < NV; v++) begin
            check_lk("R2/R3/R4/R5 table", VEC[v][122:107], VEC[v][106:68], VEC[v][67],
                     VEC[v][66:64], VEC[v][63:8], VEC[v][7:0]);
        end

        // R4 leaf address returned
        @(negedge clk); lk_asid = 16'h0001; lk_va = 39'h0012345ABC; #2;
        n_chk++;
        if (lk_leaf_pa !== 56'hABCDF000) begin
            n_fail++;
            $display("FAIL R4 leaf: got %h want %h", lk_leaf_pa, 56'hABCDF000);
        end

        // R8 update attribute only
        @(negedge clk); upd_en = 1'b1; upd_idx = 3'd0; upd_attr = 8'hCF;
        @(negedge clk); upd_en = 1'b0;
        check_lk("R8", 16'h0001, 39'h0012345ABC, 1'b1, 3'd0, 56'hABCDEABC, 8'hCF);

        // R7 level 3 dropped, pointer/slots untouched
        do_fill(16'h0001, 1'b0, 39'h0500000000, 56'h7000, 2'd3, 8'h44);
        check_lk("R7", 16'h0001, 39'h0500000000, 1'b0, 3'd0, 56'h0, 8'h00);
        do_fill(16'h0005, 1'b0, 39'h0000001000, 56'h9000, 2'd0, 8'h55);
        check_lk("R7/R6", 16'h0005, 39'h0000001ABC, 1'b1, 3'd4, 56'h9ABC, 8'h55);

        // R10 address-only flush removes global entry
        do_flush(1'b0, 1'b1, 16'h0000, 39'h00403ABCDE);
        check_lk("R10", 16'h0007, 39'h00403ABCDE, 1'b0, 3'd0, 56'h0, 8'h00);
        check_lk("R10", 16'h0001, 39'h0012345ABC, 1'b1, 3'd0, 56'hABCDEABC, 8'hCF);

        // R11 ASID-only flush
        do_flush(1'b1, 1'b0, 16'h0001, 39'h0);
        check_lk("R11", 16'h0001, 39'h0012345ABC, 1'b0, 3'd0, 56'h0, 8'h00);
        check_lk("R11", 16'h0001, 39'h0080001234, 1'b0, 3'd0, 56'h0, 8'h00);
        check_lk("R11", 16'h0005, 39'h0000001ABC, 1'b1, 3'd4, 56'h9ABC, 8'h55);

        // Global refill goes to lowest invalid (R6); ASID flush spares it (R11)
        do_fill(16'h0002, 1'b1, 39'h00403ABCDE, 56'h80612345, 2'd1, 8'h1F);
        check_lk("R6", 16'h0007, 39'h00403ABCDE, 1'b1, 3'd0, 56'h807ABCDE, 8'h1F);
        do_flush(1'b1, 1'b0, 16'h0002, 39'h0);
        check_lk("R11 global", 16'h0007, 39'h00403ABCDE, 1'b1, 3'd0, 56'h807ABCDE, 8'h1F);

        // R12 both selectors
        do_flush(1'b1, 1'b1, 16'h0002, 39'h0040200000);
        check_lk("R12 global", 16'h0007, 39'h00403ABCDE, 1'b1, 3'd0, 56'h807ABCDE, 8'h1F);
        do_flush(1'b1, 1'b1, 16'h0006, 39'h0000001FFF);
        check_lk("R12 asid miss", 16'h0005, 39'h0000001ABC, 1'b1, 3'd4, 56'h9ABC, 8'h55);
        do_flush(1'b1, 1'b1, 16'h0005, 39'h0000001FFF);
        check_lk("R12", 16'h0005, 39'h0000001ABC, 1'b0, 3'd0, 56'h0, 8'h00);

        // R9 + R13: full flush with a fill in the same cycle
        @(negedge clk);
        fl_en = 1'b1; fl_by_asid = 1'b0; fl_by_va = 1'b0;
        fill_en = 1'b1; fill_asid = 16'h0001; fill_glb = 1'b0; fill_va = 39'h0012345000;
        fill_pa = 56'hABCDE000; fill_lvl = 2'd0; fill_attr = 8'h0F;
        @(negedge clk);
        fl_en = 1'b0; fill_en = 1'b0;
        check_lk("R9", 16'h0007, 39'h00403ABCDE, 1'b0, 3'd0, 56'h0, 8'h00);
        check_lk("R13", 16'h0001, 39'h0012345ABC, 1'b0, 3'd0, 56'h0, 8'h00);

        // R6 round robin after array fills
        for (int k = 0; k < 8; k++) begin
            do_fill(16'h0009, 1'b0, 39'(k) << 12, (56'(k) + 56'h100) << 12, 2'd0, 8'h77);
        end
        for (int k = 0; k < 8; k++) begin
            check_lk("R6 fill order", 16'h0009, (39'(k) << 12) | 39'h0AB, 1'b1, 3'(k),
                     ((56'(k) + 56'h100) << 12) | 56'h0AB, 8'h77);
        end
        do_fill(16'h0009, 1'b0, 39'h0000100000, 56'h200000, 2'd0, 8'h66);
        do_fill(16'h0009, 1'b0, 39'h0000101000, 56'h201000, 2'd0, 8'h65);
        check_lk("R6 rr", 16'h0009, 39'h0000000010, 1'b0, 3'd0, 56'h0, 8'h00);
        check_lk("R6 rr", 16'h0009, 39'h0000100010, 1'b1, 3'd0, 56'h200010, 8'h66);
        check_lk("R6 rr", 16'h0009, 39'h0000101010, 1'b1, 3'd1, 56'h201010, 8'h65);
        check_lk("R6 rr", 16'h0009, 39'h0000002010, 1'b1, 3'd2, 56'h102010, 8'h77);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule